// File: doc/BRIEF.md
# Byte Compare, Popcount and Parity Unit

This block is a 64-bit bit-statistics unit for an integer datapath. It accepts two source operands and a 3-bit operation code, evaluates one of six functions combinationally, and registers the 64-bit result. The functions are a byte-by-byte equality mask, set-bit counts packed per byte, per 32-bit half or over the whole operand, and parities formed from the low bit of every byte, either per 32-bit half or over the whole operand.

Inputs are taken on a clock edge where `in_valid` is high; the result and a one-cycle `out_valid` pulse appear on the following edge. Between accepted operations the result register keeps its last value. None of the functions produce or change any flag; the 64-bit result is the only output data. Reset is asynchronous, active low, and its release is synchronised inside the block, so the first operation may be presented three cycles after `rst_n` rises.

Top module: `bitstat_unit`

## Requirements
- R1: While reset is active and after it, until the first accepted operation, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` was sampled high, and 0 otherwise.
- R3: Code 0 (byte mask): result byte k (bits 8k+7..8k) is 0xFF when byte k of `src_a` equals byte k of `src_b`, else 0x00.
- R4: Code 1 (byte count): result byte k holds the number of set bits in byte k of `src_a` (0 to 8).
- R5: Code 2 (half count): result bits 63..32 hold the set-bit count of `src_a[63:32]`, bits 31..0 that of `src_a[31:0]`; each is at most 32.
- R6: Code 3 (full count): the result is the set-bit count of all 64 bits of `src_a`, from 0 to 64.
- R7: Code 4 (half parity): result bit 0 is the XOR of `src_a` bits 0, 8, 16, 24; result bit 32 is the XOR of bits 32, 40, 48, 56; every other result bit is 0, and no other `src_a` bit affects the result.
- R8: Code 5 (full parity): result bit 0 is the XOR of `src_a` bit 8k for k = 0..7; bits 63..1 are 0.
- R9: Codes 6 and 7 give a result of 0.
- R10: In a cycle after one where `in_valid` was low, `result` keeps its previous value whatever `op_sel`, `src_a` and `src_b` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and code are taken on this edge |
| op_sel | input | 3 | Operation code (0..5 defined, 6..7 give zero) |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand, used by the byte mask only |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 64 | Registered 64-bit result |

## Verification
The bench builds the block with its defaults, a 64-bit datapath split into 8-bit bytes and two 32-bit halves, so every packing boundary is in play: byte counts that reach 8, a half count of 32 next to a count of 1, the full count of 64, and parities in both halves at bits 0 and 32. Operand patterns that set many bits outside the low bit of each byte show that the parity codes look only at those low bits. Hold behaviour, back-to-back operations and the two unused codes are driven as directed cases after the vector table.

// File: rtl/bitstat_pkg.sv
package bitstat_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_BYTE_MASK = 3'd0,
    OP_CNT_BYTE  = 3'd1,
    OP_CNT_HALF  = 3'd2,
    OP_CNT_FULL  = 3'd3,
    OP_PAR_HALF  = 3'd4,
    OP_PAR_FULL  = 3'd5
  } op_e;

endpackage

// File: rtl/bitstat_rst_sync.sv
module bitstat_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bitstat_bytemask.sv
module bitstat_bytemask #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] mask
);

  import bitstat_pkg::*;

  localparam int unsigned NBYTE = DATA_W / BYTE_W;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic same;
    assign same = (op_a[b*BYTE_W +: BYTE_W] == op_b[b*BYTE_W +: BYTE_W]);
    assign mask[b*BYTE_W +: BYTE_W] = {BYTE_W{same}};
  end

endmodule

// File: rtl/bitstat_popcnt.sv
module bitstat_popcnt #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] cnt_byte,
  output logic [DATA_W-1:0] cnt_half,
  output logic [DATA_W-1:0] cnt_full
);

  import bitstat_pkg::*;

  localparam int unsigned NBYTE   = DATA_W / BYTE_W;
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned BPH     = NBYTE / 2;
  localparam int unsigned BC_W    = $clog2(BYTE_W + 1);
  localparam int unsigned HC_W    = $clog2(HALF_W + 1);
  localparam int unsigned FC_W    = $clog2(DATA_W + 1);

  logic [BC_W-1:0] byte_cnt [NBYTE];
  logic [HC_W-1:0] half_cnt [2];
  logic [FC_W-1:0] full_cnt;

  // Level 1: count each byte
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    always_comb begin
      byte_cnt[b] = '0;
      for (int j = 0; j < int'(BYTE_W); j++) begin
        byte_cnt[b] = byte_cnt[b] + BC_W'(op_a[b*BYTE_W + j]);
      end
    end
    assign cnt_byte[b*BYTE_W +: BYTE_W] = BYTE_W'(byte_cnt[b]);
  end

  // Level 2: sum byte counts into each half
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_comb begin
      half_cnt[h] = '0;
      for (int k = 0; k < int'(BPH); k++) begin
        half_cnt[h] = half_cnt[h] + HC_W'(byte_cnt[h*BPH + k]);
      end
    end
    assign cnt_half[h*HALF_W +: HALF_W] = HALF_W'(half_cnt[h]);
  end

  // Level 3: sum the two halves
  assign full_cnt = FC_W'(half_cnt[0]) + FC_W'(half_cnt[1]);
  assign cnt_full = DATA_W'(full_cnt);

endmodule

// File: rtl/bitstat_parity.sv
module bitstat_parity #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] par_half,
  output logic [DATA_W-1:0] par_full
);

  import bitstat_pkg::*;

  localparam int unsigned NBYTE  = DATA_W / BYTE_W;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned BPH    = NBYTE / 2;

  logic [NBYTE-1:0] low_bits;
  logic [1:0]       half_par;

  for (genvar b = 0; b < NBYTE; b++) begin : g_tap
    assign low_bits[b] = op_a[b*BYTE_W];
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_par[h] = ^low_bits[h*BPH +: BPH];
    assign par_half[h*HALF_W +: HALF_W] = {{(HALF_W-1){1'b0}}, half_par[h]};
  end

  assign par_full = {{(DATA_W-1){1'b0}}, ^half_par};

endmodule

// File: rtl/bitstat_unit.sv
module bitstat_unit #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  import bitstat_pkg::*;

  logic              rst_n_int;
  logic [DATA_W-1:0] mask_w;
  logic [DATA_W-1:0] cnt_byte_w;
  logic [DATA_W-1:0] cnt_half_w;
  logic [DATA_W-1:0] cnt_full_w;
  logic [DATA_W-1:0] par_half_w;
  logic [DATA_W-1:0] par_full_w;
  logic [DATA_W-1:0] result_d;
  logic [DATA_W-1:0] result_q;
  logic              valid_q;

  bitstat_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bitstat_bytemask #(.DATA_W(DATA_W)) u_mask (
    .op_a (src_a),
    .op_b (src_b),
    .mask (mask_w)
  );

  bitstat_popcnt #(.DATA_W(DATA_W)) u_cnt (
    .op_a     (src_a),
    .cnt_byte (cnt_byte_w),
    .cnt_half (cnt_half_w),
    .cnt_full (cnt_full_w)
  );

  bitstat_parity #(.DATA_W(DATA_W)) u_par (
    .op_a     (src_a),
    .par_half (par_half_w),
    .par_full (par_full_w)
  );

  // Next-state: operation select
  always_comb begin
    unique case (op_sel)
      OP_BYTE_MASK: result_d = mask_w;
      OP_CNT_BYTE:  result_d = cnt_byte_w;
      OP_CNT_HALF:  result_d = cnt_half_w;
      OP_CNT_FULL:  result_d = cnt_full_w;
      OP_PAR_HALF:  result_d = par_half_w;
      OP_PAR_FULL:  result_d = par_full_w;
      default:      result_d = '0;
    endcase
  end

  // Registers: result loads only under in_valid
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      result_q <= '0;
    end else if (in_valid) begin
      result_q <= result_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;

endmodule

// File: rtl/bitstat_unit_chk.sv
module bitstat_unit_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op_sel,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic unused_ok;
  assign unused_ok = ^{src_a, src_b};

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R6
  full_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd3) |=> (result <= DATA_W'(DATA_W)));

  // R5
  half_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd2) |=>
      (result[HALF_W-1:0] <= HALF_W'(HALF_W)) &&
      (result[DATA_W-1:HALF_W] <= HALF_W'(HALF_W)));

  // R7
  half_par_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd4) |=>
      (result[HALF_W-1:1] == '0) && (result[DATA_W-1:HALF_W+1] == '0));

  // R8
  full_par_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd5) |=> (result[DATA_W-1:1] == '0));

  // R9
  bad_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel > 3'd5) |=> (result == '0));

endmodule

bind bitstat_unit bitstat_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .src_a     (src_a),
  .src_b     (src_b),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/bitstat_unit_tb.sv
module bitstat_unit_tb_top;

  localparam int NV = 14;

  localparam logic [2:0] V_OP [NV] = '{
    3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3,
    3'd3, 3'd4, 3'd4, 3'd5, 3'd5, 3'd6, 3'd7};
  localparam logic [63:0] V_A [NV] = '{
    64'h0011223344556677, 64'h123456789ABCDEF0,
    64'hFF0103070F1F3F7F, 64'h0000000000000000,
    64'hFFFFFFFF00000001, 64'h80000000F0F0F0F0,
    64'hFFFFFFFFFFFFFFFF, 64'h0000000100000003,
    64'h0100000001010000, 64'hFEFEFEFE00000001,
    64'h0101010101010101, 64'hFEFEFEFEFEFEFE01,
    64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF};
  localparam logic [63:0] V_B [NV] = '{
    64'h0011AA3344BB6677, 64'h123456789ABCDEF0,
    64'h0, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h0, 64'h0,
    64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
    64'h0, 64'h0123456789ABCDEF};
  localparam logic [63:0] V_EXP [NV] = '{
    64'hFFFF00FFFF00FFFF, 64'hFFFFFFFFFFFFFFFF,
    64'h0801020304050607, 64'h0000000000000000,
    64'h0000002000000001, 64'h0000000100000010,
    64'h0000000000000040, 64'h0000000000000003,
    64'h0000000100000000, 64'h0000000000000001,
    64'h0000000000000000, 64'h0000000000000001,
    64'h0000000000000000, 64'h0000000000000000};
  localparam string V_REQ [NV] = '{
    "R3", "R3", "R4", "R4", "R5", "R5", "R6",
    "R6", "R7", "R7", "R8", "R8", "R9", "R9"};

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic        out_valid;
  logic [63:0] result;

  int n_chk;
  int n_fail;
  bit done;

  bitstat_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one operation, then sample at the next falling edge.
  task automatic issue(input logic [2:0] op, input logic [63:0] a,
                       input logic [63:0] b);
    @(negedge clk);
    op_sel   = op;
    src_a    = a;
    src_b    = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures",
               n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op_sel   = 3'd0;
    src_a    = '0;
    src_b    = '0;

    // R1: during reset
    repeat (3) @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    check("R1", result, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: after release, before any operation
    check("R1", {63'd0, out_valid}, 64'd0);
    check("R1", result, 64'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      issue(V_OP[i], V_A[i], V_B[i]);
      check("R2", {63'd0, out_valid}, 64'd1);
      check(V_REQ[i], result, V_EXP[i]);
      @(negedge clk);
      check("R2", {63'd0, out_valid}, 64'd0);
    end

    // R10: result holds while in_valid is low and inputs change
    issue(3'd1, 64'hFF0103070F1F3F7F, 64'h0);
    op_sel = 3'd3;
    src_a  = 64'hFFFFFFFFFFFFFFFF;
    src_b  = 64'h1;
    repeat (3) @(negedge clk);
    check("R10", result, 64'h0801020304050607);
    check("R2", {63'd0, out_valid}, 64'd0);

    // R2: back-to-back operations, each result in its own cycle
    @(negedge clk);
    op_sel = 3'd3; src_a = 64'h00000000000000FF; in_valid = 1'b1;
    @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd1);
    check("R6", result, 64'd8);
    op_sel = 3'd0; src_a = 64'h5; src_b = 64'h5;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {63'd0, out_valid}, 64'd1);
    check("R3", result, 64'hFFFFFFFFFFFFFFFF);
    @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd0);

    // R7: parity taps only the low bit of each byte (upper half set)
    issue(3'd4, 64'h0000000100000000, 64'h0);
    check("R7", result, 64'h0000000100000000);
    // R8: single low bit in the top byte
    issue(3'd5, 64'h0100000000000000, 64'h0);
    check("R8", result, 64'h1);
    // R4: alternating pattern, 4 per byte
    issue(3'd1, 64'hAA55AA55AA55AA55, 64'h0);
    check("R4", result, 64'h0404040404040404);

    finish_run();
  end

endmodule